// File: doc/BRIEF.md
# Cache Tag Array Access Port

This block lets software reach the tag store of a four-way set-associative cache through plain load and store requests. A request that lands in the tag window can read one way of a set, overwrite one way of a set, or run an associative write. An associative write compares a supplied tag against every valid way of the addressed set and changes only the dirty (U) and valid (V) bits of the way that matches. A write that would overwrite or invalidate a line that is both dirty and valid first hands the old line's tag, set and way to the write-back logic on a valid/ready handshake. The block holds `busy` high until that handshake completes and only then commits the update.

A second address window, for the cache data array, is not served here. For that window the block only decodes way, set and longword selects for the data-array logic beside it. Each stored entry holds a 22-bit tag, 6 replacement (LRU) bits, U and V. The store has 256 sets of 4 ways and comes out of reset all zero.

The controller has three states. `ST_IDLE` accepts requests. `ST_RESP` is the one cycle in which read data is returned. `ST_WBWAIT` holds a write-back request open. The transitions are:
- IDLE→RESP on an aligned read.
- IDLE→WBWAIT on a write whose target line is dirty and valid.
- IDLE→IDLE on every other request; a clean write commits on that same edge.
- RESP→IDLE always.
- WBWAIT→IDLE on the edge where `wb_ready` is high, which is also the edge that commits the pending update.

Top module: `cache_tag_port`

## Requirements
- R1: After reset every entry reads as zero (tag, LRU, U and V all 0), and `busy`, `rsp_valid`, `wb_valid` and `req_err` are low.
- R2: A request is taken only when `req_valid` is high and `busy` is low. The tag window is `req_addr[31:24]` = 0xF0. Within it, bits 13:12 give the way, bits 11:4 the set and bit 3 the associative flag A, while bits 23:14 and bit 2 are ignored. Requests outside both windows have no effect.
- R3: A tag-window read raises `rsp_valid` for exactly one cycle, the cycle after the request. `rsp_data` is laid out as tag in bits 31:10, LRU in bits 9:4, zero in bits 3:2, U in bit 1 and V in bit 0. A read never compares tags, whatever A is, and never starts a write-back.
- R4: A write with A=0 stores the tag, LRU, U and V of `req_wdata` (same layout as `rsp_data`) into the addressed way, and a following read returns them.
- R5: A write with A=0 whose target holds U=1 and V=1 raises `wb_valid` in the next cycle, with the old tag, the set and the way. Those fields stay stable while `wb_ready` is low, and the new entry is stored on the edge where `wb_ready` is seen high.
- R6: A write with A=1 compares the data-field tag against the valid ways of the set. On a hit, only U and V of the matching way are written, and its tag and LRU keep their old values. When several ways match, the lowest-numbered way is the one written.
- R7: A write with A=1 that matches no valid way changes no entry and starts no write-back.
- R8: A write with A=1 that hits a way holding U=1 starts a write-back of that way (old tag, set, way) before updating it.
- R9: Whenever a write stores V=0, U is stored as 0, whatever the data field carries.
- R10: A tag-window request with `req_addr[1:0]` nonzero raises `req_err` for one cycle, the cycle after the request. It leaves the store unchanged and produces no response and no write-back.
- R11: `dsel_valid` is high in the same cycle exactly when `req_valid` is high, `req_addr[31:24]` = 0xF1 and `req_addr[1:0]` = 00. When it is high, `dsel_way` = bits 13:12, `dsel_set` = bits 11:4 and `dsel_word` = bits 3:2. Data-window requests never touch the tag store.
- R12: `busy` is high in the response cycle of a read and throughout a write-back wait, and low otherwise. Tag-window requests made while it is high are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 32 | Request address |
| req_wdata | input | 32 | Write data field |
| busy | output | 1 | Port cannot take a request |
| rsp_valid | output | 1 | Read data valid |
| rsp_data | output | 32 | Read data, zero when not valid |
| req_err | output | 1 | Misaligned tag-window request seen |
| wb_valid | output | 1 | Write-back request |
| wb_ready | input | 1 | Write-back accepted |
| wb_tag | output | 22 | Tag of line to write back |
| wb_set | output | 8 | Set of line to write back |
| wb_way | output | 2 | Way of line to write back |
| dsel_valid | output | 1 | Data-array access decoded |
| dsel_way | output | 2 | Data-array way select |
| dsel_set | output | 8 | Data-array set select |
| dsel_word | output | 2 | Longword within line |

## Verification
Several properties are checked on every cycle:
- A read response is a single pulse in the cycle after an accepted read, with no write-back.
- A misaligned tag-window request yields an error pulse with nothing else.
- A write-back request stays stable until it is accepted.
- Any returned entry with V=0 also shows U=0.

Other behaviour is visible only through the bench's scenarios, run against its behavioural model of the store. This covers which way an associative write picks, that tag and LRU survive an associative hit, and that a miss or an ignored request leaves every entry untouched. It also covers that the update lands exactly at the handshake edge; the model holds the store contents over time, and the assertions do not.

// File: rtl/ctp_pkg.sv
package ctp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RESP   = 2'd1,
        ST_WBWAIT = 2'd2
    } ctp_state_e;

endpackage

// File: rtl/ctp_addr_decode.sv
module ctp_addr_decode #(
    parameter int ADDR_W   = 32,
    parameter int WAY_W    = 2,
    parameter int SET_W    = 8,
    parameter int WORD_W   = 2,
    parameter int WIN_W    = 8,
    parameter logic [7:0] TAG_WIN  = 8'hF0,
    parameter logic [7:0] DATA_WIN = 8'hF1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              in_tag_win,
    output logic              in_data_win,
    output logic              aligned,
    output logic              assoc,
    output logic [WAY_W-1:0]  way,
    output logic [SET_W-1:0]  set,
    output logic [WORD_W-1:0] word
);
    localparam int ALIGN_W = 2;
    localparam int WORD_LSB = ALIGN_W;
    localparam int SET_LSB  = WORD_LSB + WORD_W;
    localparam int WAY_LSB  = SET_LSB + SET_W;
    localparam int ASSOC_B  = SET_LSB - 1;
    localparam int WIN_LSB  = ADDR_W - WIN_W;

    logic [WIN_W-1:0] win;

    always_comb begin
        win         = addr[WIN_LSB +: WIN_W];
        in_tag_win  = (win == TAG_WIN[WIN_W-1:0]);
        in_data_win = (win == DATA_WIN[WIN_W-1:0]);
        aligned     = (addr[ALIGN_W-1:0] == '0);
        assoc       = addr[ASSOC_B];
        way         = addr[WAY_LSB +: WAY_W];
        set         = addr[SET_LSB +: SET_W];
        word        = addr[WORD_LSB +: WORD_W];
    end

endmodule

// File: rtl/ctp_tag_store.sv
module ctp_tag_store #(
    parameter int WAYS  = 4,
    parameter int SETS  = 256,
    parameter int ENT_W = 30,
    parameter int WAY_W = 2,
    parameter int SET_W = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [SET_W-1:0]            rd_set,
    output logic [WAYS-1:0][ENT_W-1:0]  rd_ent,
    input  logic                        we,
    input  logic [WAY_W-1:0]            wr_way,
    input  logic [SET_W-1:0]            wr_set,
    input  logic [ENT_W-1:0]            wr_ent
);

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic [ENT_W-1:0] mem [SETS];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int s = 0; s < SETS; s++) begin
                    mem[s] <= '0;
                end
            end else if (we && (wr_way == WAY_W'(w))) begin
                mem[wr_set] <= wr_ent;
            end
        end

        assign rd_ent[w] = mem[rd_set];
    end

endmodule

// File: rtl/ctp_tag_match.sv
module ctp_tag_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 22,
    parameter int ENT_W = 30,
    parameter int WAY_W = 2
) (
    input  logic [WAYS-1:0][ENT_W-1:0] ent,
    input  logic [TAG_W-1:0]           tag,
    output logic                       hit,
    output logic [WAY_W-1:0]           hit_way
);
    logic [WAYS-1:0] way_hit;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign way_hit[w] = ent[w][0] && (ent[w][ENT_W-1 -: TAG_W] == tag);
    end

    always_comb begin
        hit     = |way_hit;
        hit_way = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (way_hit[i]) begin
                hit_way = WAY_W'(i);
            end
        end
    end

endmodule

// File: rtl/ctp_ctrl.sv
module ctp_ctrl
    import ctp_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int WAYS   = 4,
    parameter int TAG_W  = 22,
    parameter int LRU_W  = 6,
    parameter int ENT_W  = 30,
    parameter int WAY_W  = 2,
    parameter int SET_W  = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    input  logic                        req_write,
    input  logic [DATA_W-1:0]           req_wdata,
    input  logic                        in_tag_win,
    input  logic                        aligned,
    input  logic                        assoc,
    input  logic [WAY_W-1:0]            dec_way,
    input  logic [SET_W-1:0]            dec_set,
    input  logic [WAYS-1:0][ENT_W-1:0]  rd_ent,
    input  logic                        hit,
    input  logic [WAY_W-1:0]            hit_way,
    input  logic                        wb_ready,
    output logic [SET_W-1:0]            rd_set,
    output logic                        we,
    output logic [WAY_W-1:0]            wr_way,
    output logic [SET_W-1:0]            wr_set,
    output logic [ENT_W-1:0]            wr_ent,
    output logic                        busy,
    output logic                        rsp_valid,
    output logic [DATA_W-1:0]           rsp_data,
    output logic                        req_err,
    output logic                        wb_valid,
    output logic [TAG_W-1:0]            wb_tag,
    output logic [SET_W-1:0]            wb_set,
    output logic [WAY_W-1:0]            wb_way
);
    localparam int PAD_W   = DATA_W - ENT_W;
    localparam int LRU_MSB = DATA_W - TAG_W - 1;

    ctp_state_e state_q, state_d;

    logic [SET_W-1:0] cap_set_q;
    logic [WAY_W-1:0] cap_way_q;
    logic [ENT_W-1:0] pend_ent_q;
    logic [TAG_W-1:0] wb_tag_q;
    logic             err_q;

    logic             idle, accept, good;
    logic             op_read, op_dwr, op_awr;
    logic             do_write, need_wb;
    logic [WAY_W-1:0] tgt_way;
    logic [ENT_W-1:0] old_ent, new_ent, rsp_ent;
    logic             new_u, new_v;

    // request classification in the idle state
    always_comb begin
        idle     = (state_q == ST_IDLE);
        accept   = req_valid && idle && in_tag_win;
        good     = accept && aligned;
        op_read  = good && !req_write;
        op_dwr   = good && req_write && !assoc;
        op_awr   = good && req_write && assoc;
        tgt_way  = op_awr ? hit_way : dec_way;
        old_ent  = rd_ent[tgt_way];
        new_v    = req_wdata[0];
        new_u    = req_wdata[1] && req_wdata[0];
        if (op_dwr) begin
            new_ent = {req_wdata[DATA_W-1 -: TAG_W], req_wdata[LRU_MSB -: LRU_W], new_u, new_v};
        end else begin
            new_ent = {old_ent[ENT_W-1:2], new_u, new_v};
        end
        do_write = op_dwr || (op_awr && hit);
        need_wb  = do_write && old_ent[1] && old_ent[0];
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (op_read) begin
                    state_d = ST_RESP;
                end else if (need_wb) begin
                    state_d = ST_WBWAIT;
                end
            end
            ST_RESP: state_d = ST_IDLE;
            ST_WBWAIT: begin
                if (wb_ready) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // captured request context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_set_q  <= '0;
            cap_way_q  <= '0;
            pend_ent_q <= '0;
            wb_tag_q   <= '0;
            err_q      <= 1'b0;
        end else begin
            err_q <= accept && !aligned;
            if (good) begin
                cap_set_q  <= dec_set;
                cap_way_q  <= tgt_way;
                pend_ent_q <= new_ent;
                wb_tag_q   <= old_ent[ENT_W-1 -: TAG_W];
            end
        end
    end

    // outputs
    always_comb begin
        rd_set    = dec_set;
        we        = 1'b0;
        wr_way    = tgt_way;
        wr_set    = dec_set;
        wr_ent    = new_ent;
        busy      = 1'b1;
        rsp_valid = 1'b0;
        rsp_data  = '0;
        wb_valid  = 1'b0;
        rsp_ent   = rd_ent[cap_way_q];
        unique case (state_q)
            ST_IDLE: begin
                busy = 1'b0;
                we   = do_write && !need_wb;
            end
            ST_RESP: begin
                rd_set    = cap_set_q;
                rsp_valid = 1'b1;
                rsp_data  = {rsp_ent[ENT_W-1:2], {PAD_W{1'b0}}, rsp_ent[1:0]};
            end
            ST_WBWAIT: begin
                rd_set   = cap_set_q;
                wb_valid = 1'b1;
                we       = wb_ready;
                wr_way   = cap_way_q;
                wr_set   = cap_set_q;
                wr_ent   = pend_ent_q;
            end
            default: busy = 1'b0;
        endcase
        req_err = err_q;
        wb_tag  = wb_tag_q;
        wb_set  = cap_set_q;
        wb_way  = cap_way_q;
    end

endmodule

// File: rtl/cache_tag_port.sv
module cache_tag_port #(
    parameter int DATA_W = 32,
    parameter int WAYS   = 4,
    parameter int SETS   = 256,
    parameter int TAG_W  = 22,
    parameter int LRU_W  = 6,
    parameter int WORD_W = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    input  logic                      req_write,
    input  logic [DATA_W-1:0]         req_addr,
    input  logic [DATA_W-1:0]         req_wdata,
    output logic                      busy,
    output logic                      rsp_valid,
    output logic [DATA_W-1:0]         rsp_data,
    output logic                      req_err,
    output logic                      wb_valid,
    input  logic                      wb_ready,
    output logic [TAG_W-1:0]          wb_tag,
    output logic [$clog2(SETS)-1:0]   wb_set,
    output logic [$clog2(WAYS)-1:0]   wb_way,
    output logic                      dsel_valid,
    output logic [$clog2(WAYS)-1:0]   dsel_way,
    output logic [$clog2(SETS)-1:0]   dsel_set,
    output logic [WORD_W-1:0]         dsel_word
);
    localparam int WAY_W = $clog2(WAYS);
    localparam int SET_W = $clog2(SETS);
    localparam int ENT_W = TAG_W + LRU_W + 2;

    logic                       in_tag_win, in_data_win, aligned, assoc;
    logic [WAY_W-1:0]           dec_way, hit_way, wr_way;
    logic [SET_W-1:0]           dec_set, rd_set, wr_set;
    logic [WORD_W-1:0]          dec_word;
    logic [WAYS-1:0][ENT_W-1:0] rd_ent;
    logic                       hit, we;
    logic [ENT_W-1:0]           wr_ent;

    ctp_addr_decode #(
        .ADDR_W (DATA_W),
        .WAY_W  (WAY_W),
        .SET_W  (SET_W),
        .WORD_W (WORD_W)
    ) u_dec (
        .addr        (req_addr),
        .in_tag_win  (in_tag_win),
        .in_data_win (in_data_win),
        .aligned     (aligned),
        .assoc       (assoc),
        .way         (dec_way),
        .set         (dec_set),
        .word        (dec_word)
    );

    ctp_tag_store #(
        .WAYS  (WAYS),
        .SETS  (SETS),
        .ENT_W (ENT_W),
        .WAY_W (WAY_W),
        .SET_W (SET_W)
    ) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_set (rd_set),
        .rd_ent (rd_ent),
        .we     (we),
        .wr_way (wr_way),
        .wr_set (wr_set),
        .wr_ent (wr_ent)
    );

    ctp_tag_match #(
        .WAYS  (WAYS),
        .TAG_W (TAG_W),
        .ENT_W (ENT_W),
        .WAY_W (WAY_W)
    ) u_match (
        .ent     (rd_ent),
        .tag     (req_wdata[DATA_W-1 -: TAG_W]),
        .hit     (hit),
        .hit_way (hit_way)
    );

    ctp_ctrl #(
        .DATA_W (DATA_W),
        .WAYS   (WAYS),
        .TAG_W  (TAG_W),
        .LRU_W  (LRU_W),
        .ENT_W  (ENT_W),
        .WAY_W  (WAY_W),
        .SET_W  (SET_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_wdata  (req_wdata),
        .in_tag_win (in_tag_win),
        .aligned    (aligned),
        .assoc      (assoc),
        .dec_way    (dec_way),
        .dec_set    (dec_set),
        .rd_ent     (rd_ent),
        .hit        (hit),
        .hit_way    (hit_way),
        .wb_ready   (wb_ready),
        .rd_set     (rd_set),
        .we         (we),
        .wr_way     (wr_way),
        .wr_set     (wr_set),
        .wr_ent     (wr_ent),
        .busy       (busy),
        .rsp_valid  (rsp_valid),
        .rsp_data   (rsp_data),
        .req_err    (req_err),
        .wb_valid   (wb_valid),
        .wb_tag     (wb_tag),
        .wb_set     (wb_set),
        .wb_way     (wb_way)
    );

    // data-array window: pure decode for neighbouring logic
    always_comb begin
        dsel_valid = req_valid && in_data_win && aligned;
        dsel_way   = dec_way;
        dsel_set   = dec_set;
        dsel_word  = dec_word;
    end

endmodule

// File: rtl/cache_tag_port_chk.sv
module cache_tag_port_chk #(
    parameter int DATA_W = 32,
    parameter int TAG_W  = 22,
    parameter int SET_W  = 8,
    parameter int WAY_W  = 2,
    parameter logic [7:0] TAG_WIN = 8'hF0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [DATA_W-1:0] req_addr,
    input logic              busy,
    input logic              rsp_valid,
    input logic [DATA_W-1:0] rsp_data,
    input logic              req_err,
    input logic              wb_valid,
    input logic              wb_ready,
    input logic [TAG_W-1:0]  wb_tag,
    input logic [SET_W-1:0]  wb_set,
    input logic [WAY_W-1:0]  wb_way
);
    logic tag_take;
    assign tag_take = req_valid && !busy && (req_addr[DATA_W-1 -: 8] == TAG_WIN);

    p_rd_rsp_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tag_take && !req_write && req_addr[1:0] == 2'b00) |=> (rsp_valid && !wb_valid));

    p_rsp_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    p_err_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (tag_take && req_addr[1:0] != 2'b00) |=> (req_err && !rsp_valid && !wb_valid));

    p_wb_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_tag) && $stable(wb_set) && $stable(wb_way)));

    p_busy_cover_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid || wb_valid) |-> busy);

    p_v_clears_u_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_data[0]) |-> !rsp_data[1]);

    p_rsp_pad_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_data[3:2] == 2'b00));

endmodule

bind cache_tag_port cache_tag_port_chk #(
    .DATA_W (DATA_W),
    .TAG_W  (TAG_W),
    .SET_W  ($clog2(SETS)),
    .WAY_W  ($clog2(WAYS))
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .busy      (busy),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .req_err   (req_err),
    .wb_valid  (wb_valid),
    .wb_ready  (wb_ready),
    .wb_tag    (wb_tag),
    .wb_set    (wb_set),
    .wb_way    (wb_way)
);

// File: tb/cache_tag_port_test.sv
module cache_tag_port_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, wb_ready = 1'b0;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic        busy, rsp_valid, req_err, wb_valid, dsel_valid;
    logic [31:0] rsp_data;
    logic [21:0] wb_tag;
    logic [7:0]  wb_set, dsel_set;
    logic [1:0]  wb_way, dsel_way, dsel_word;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    cache_tag_port uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .req_err(req_err),
        .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_tag(wb_tag),
        .wb_set(wb_set), .wb_way(wb_way), .dsel_valid(dsel_valid),
        .dsel_way(dsel_way), .dsel_set(dsel_set), .dsel_word(dsel_word)
    );

    // behavioural reference model
    logic [21:0] m_tag [4][256];
    logic [5:0]  m_lru [4][256];
    logic        m_u   [4][256];
    logic        m_v   [4][256];
    int          m_st = 0;          // 0 idle, 1 respond, 2 write-back wait
    logic        e_rsp = 0, e_err = 0;
    logic [31:0] e_rdata = '0;
    logic [21:0] e_wbtag = '0;
    int          p_way = 0, p_set = 0;
    logic [21:0] p_tag;
    logic [5:0]  p_lru;
    logic        p_u, p_v;

    function automatic logic [31:0] wd(input logic [21:0] t, input logic [5:0] l,
                                       input logic u, input logic v);
        return {t, l, 2'b00, u, v};
    endfunction

    function automatic logic [31:0] taddr(input int way, input int set, input logic a);
        return {8'hF0, 10'h000, 2'(way), 8'(set), a, 1'b0, 2'b00};
    endfunction

    task automatic chk(input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    task automatic model_apply();
        m_tag[p_way][p_set] = p_tag;
        m_lru[p_way][p_set] = p_lru;
        m_u[p_way][p_set]   = p_u;
        m_v[p_way][p_set]   = p_v;
    endtask

    task automatic model_edge(input logic v, input logic w, input logic [31:0] a,
                              input logic [31:0] d, input logic rdy);
        int way, set, hw;
        e_rsp = 0;
        e_err = 0;
        if (m_st == 1) begin
            m_st = 0;
        end else if (m_st == 2) begin
            if (rdy) begin
                model_apply();
                m_st = 0;
            end
        end else if (v && a[31:24] == 8'hF0) begin
            way = int'(a[13:12]);
            set = int'(a[11:4]);
            if (a[1:0] != 2'b00) begin
                e_err = 1;
            end else if (!w) begin
                e_rsp = 1;
                e_rdata = wd(m_tag[way][set], m_lru[way][set], m_u[way][set], m_v[way][set]);
                m_st = 1;
            end else begin
                hw = -1;
                if (!a[3]) begin
                    hw = way;
                    p_tag = d[31:10];
                    p_lru = d[9:4];
                end else begin
                    for (int i = 3; i >= 0; i--) begin
                        if (m_v[i][set] && m_tag[i][set] == d[31:10]) hw = i;
                    end
                    if (hw >= 0) begin
                        p_tag = m_tag[hw][set];
                        p_lru = m_lru[hw][set];
                    end
                end
                if (hw >= 0) begin
                    p_way = hw;
                    p_set = set;
                    p_v = d[0];
                    p_u = d[0] & d[1];
                    if (m_u[hw][set] && m_v[hw][set]) begin
                        e_wbtag = m_tag[hw][set];
                        m_st = 2;
                    end else begin
                        model_apply();
                    end
                end
            end
        end
    endtask

    task automatic step(input logic v, input logic w, input logic [31:0] a,
                        input logic [31:0] d, input logic rdy);
        logic exp_dv;
        req_valid = v; req_write = w; req_addr = a; req_wdata = d; wb_ready = rdy;
        #1;
        exp_dv = v && a[31:24] == 8'hF1 && a[1:0] == 2'b00;
        chk("R11", "dsel_valid", 32'(dsel_valid), 32'(exp_dv));
        if (exp_dv) begin
            chk("R11", "dsel_fields", {dsel_way, dsel_set, dsel_word},
                32'({a[13:12], a[11:4], a[3:2]}));
        end
        @(posedge clk);
        model_edge(v, w, a, d, rdy);
        @(negedge clk);
        chk("R12", "busy", 32'(busy), 32'(m_st != 0));
        chk("R3", "rsp_valid", 32'(rsp_valid), 32'(e_rsp));
        if (e_rsp) chk("R4", "rsp_data", rsp_data, e_rdata);
        chk("R5", "wb_valid", 32'(wb_valid), 32'(m_st == 2));
        if (m_st == 2) chk("R5", "wb_line", {wb_tag, wb_set, wb_way}, {e_wbtag, 8'(p_set), 2'(p_way)});
        chk("R10", "req_err", 32'(req_err), 32'(e_err));
    endtask

    task automatic idle();
        step(0, 0, 32'h0, 32'h0, 0);
    endtask

    task automatic rd_expect(input int way, input int set, input logic [31:0] exp,
                             input string rq);
        step(1, 0, taddr(way, set, 0), 32'h0, 0);
        chk(rq, "readback", rsp_data, exp);
        idle();
    endtask

    task automatic wr(input int way, input int set, input logic a, input logic [31:0] d);
        step(1, 1, taddr(way, set, a), d, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int w = 0; w < 4; w++)
            for (int s = 0; s < 256; s++) begin
                m_tag[w][s] = '0; m_lru[w][s] = '0; m_u[w][s] = 0; m_v[w][s] = 0;
            end
        repeat (3) @(negedge clk);
        chk("R1", "outputs_in_reset", {busy, rsp_valid, wb_valid, req_err}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "outputs_after_reset", {busy, rsp_valid, wb_valid, req_err}, 32'h0);
        rd_expect(2, 5, 32'h0, "R1");

        // R4 direct writes
        wr(1, 3, 0, wd(22'h12345, 6'h15, 0, 1));
        wr(0, 3, 0, wd(22'h0ABCD, 6'h2A, 1, 1));
        rd_expect(1, 3, wd(22'h12345, 6'h15, 0, 1), "R4");
        rd_expect(0, 3, wd(22'h0ABCD, 6'h2A, 1, 1), "R4");

        // R2 ignored address bits and foreign window
        step(1, 0, taddr(1, 3, 0) | 32'h00FFC004, 32'h0, 0);
        chk("R2", "ignored_bits", rsp_data, wd(22'h12345, 6'h15, 0, 1));
        idle();
        step(1, 1, 32'hE0001030, wd(22'h3FFFF, 6'h3F, 1, 1), 0);
        rd_expect(1, 3, wd(22'h12345, 6'h15, 0, 1), "R2");

        // R9 V=0 forces U=0
        wr(2, 3, 0, wd(22'h00777, 6'h01, 1, 0));
        rd_expect(2, 3, wd(22'h00777, 6'h01, 0, 0), "R9");

        // R5 write-back on direct overwrite, R12 requests dropped while busy
        wr(1, 7, 0, wd(22'h0AAAA, 6'h05, 1, 1));
        wr(1, 7, 0, wd(22'h0BBBB, 6'h06, 0, 1));
        chk("R5", "wb_tag_old", 32'(wb_tag), 32'h0AAAA);
        step(1, 0, taddr(0, 3, 0), 32'h0, 0);
        chk("R12", "busy_drop_read", 32'(rsp_valid), 32'h0);
        step(1, 1, taddr(0, 3, 0), wd(22'h1, 6'h1, 0, 0), 0);
        step(0, 0, 32'h0, 32'h0, 1);
        chk("R5", "wb_done", 32'(wb_valid), 32'h0);
        rd_expect(1, 7, wd(22'h0BBBB, 6'h06, 0, 1), "R5");
        rd_expect(0, 3, wd(22'h0ABCD, 6'h2A, 1, 1), "R12");

        // R7 associative miss
        wr(0, 3, 1, wd(22'h3FFFF, 6'h00, 0, 0));
        chk("R7", "no_wb", 32'(wb_valid), 32'h0);
        rd_expect(0, 3, wd(22'h0ABCD, 6'h2A, 1, 1), "R7");
        rd_expect(1, 3, wd(22'h12345, 6'h15, 0, 1), "R7");

        // R6 associative hit on clean line: only U/V written
        wr(3, 3, 1, wd(22'h12345, 6'h3F, 1, 1));
        rd_expect(1, 3, wd(22'h12345, 6'h15, 1, 1), "R6");

        // R8 associative hit on dirty line triggers write-back
        wr(0, 3, 1, wd(22'h12345, 6'h00, 1, 0));
        chk("R8", "wb_line", {wb_tag, wb_set, wb_way}, {22'h12345, 8'd3, 2'd1});
        step(0, 0, 32'h0, 32'h0, 0);
        step(0, 0, 32'h0, 32'h0, 1);
        rd_expect(1, 3, wd(22'h12345, 6'h15, 0, 0), "R8");

        // R6 lowest matching way wins
        wr(0, 9, 0, wd(22'h00042, 6'h01, 0, 1));
        wr(2, 9, 0, wd(22'h00042, 6'h02, 0, 1));
        wr(1, 9, 1, wd(22'h00042, 6'h00, 1, 1));
        rd_expect(0, 9, wd(22'h00042, 6'h01, 1, 1), "R6");
        rd_expect(2, 9, wd(22'h00042, 6'h02, 0, 1), "R6");

        // R3 read with A=1 of a dirty line: no compare, no write-back
        step(1, 0, taddr(0, 9, 1), wd(22'h3FFFF, 0, 0, 0), 0);
        chk("R3", "assoc_read", rsp_data, wd(22'h00042, 6'h01, 1, 1));
        chk("R3", "read_no_wb", 32'(wb_valid), 32'h0);
        idle();

        // R10 misaligned write
        step(1, 1, taddr(0, 9, 0) | 32'h2, wd(22'h1, 6'h1, 0, 0), 0);
        chk("R10", "err_pulse", 32'(req_err), 32'h1);
        idle();
        rd_expect(0, 9, wd(22'h00042, 6'h01, 1, 1), "R10");

        // R11 data window decode
        step(1, 1, 32'hF1002A98, wd(22'h2, 6'h2, 0, 0), 0);
        step(1, 0, 32'hF1003FFC, 32'h0, 0);
        step(1, 0, 32'hF1003FFD, 32'h0, 0);
        step(0, 0, 32'hF1000000, 32'h0, 0);
        step(1, 1, 32'hF1000090, wd(22'h00042, 6'h0, 0, 0), 0);
        rd_expect(0, 9, wd(22'h00042, 6'h01, 1, 1), "R11");

        // mixed traffic against the model
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] a, d;
            logic        v, w;
            v = ($urandom % 4) != 0;
            w = ($urandom % 2) != 0;
            a = taddr(int'($urandom % 4), int'($urandom % 4), 1'($urandom % 2));
            if ($urandom % 16 == 0) a[1:0] = 2'($urandom % 4);
            if ($urandom % 16 == 0) a[31:24] = 8'hF1;
            d = wd(22'($urandom % 3 + 1), 6'($urandom), 1'($urandom), 1'($urandom));
            step(v, w, a, d, 1'($urandom % 2));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule